// File: doc/BRIEF.md
# Coarse-to-Fine Photon Position Search Stage

This block is one stage of a pipelined search that locates where a photon struck a continuous scintillation crystal. The crystal is read by an 8x8 sensor array, so each event carries 64 unsigned energies. The stage receives an event together with a centre point in its own local grid. It scores the 3x3 neighbourhood of that centre and keeps the best-scoring point. It then hands the event and a refined centre to the next stage.

The score of a location is the sum over all 64 sensors of (E - A)^2 * B + C. A, B and C are coefficients computed ahead of time for each location and each sensor. They are held in a local table that is filled through a write port. A lower score means a more likely location.

The stage grids have edge lengths 3, 7, 15, 31, 63 and 127. The grid of each stage has half the spacing of the one before it. A point i in a stage with edge N therefore becomes point 2i+1 in the next stage, whose edge is 2N+1. Several stages are chained so that successive events overlap, one event per stage.

Top module: `pos_search_stage`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0.
- R2: While an event is being scored or is waiting at the output, in_ready is 0. Any in_valid, energies or centre driven in that time are ignored: the output event is unchanged.
- R3: out_valid rises exactly 3*NS clock edges after the accepting edge (192 for NS = 64). Each of the three passes scores one row of the 3x3 pattern, one sensor per cycle.
- R4: out_metric is the minimum, over the eligible points, of the sum over sensors of (E - A)^2 * B + C.
  - E and A are unsigned.
  - B is unsigned.
  - C is a signed two's-complement value.
  - The sum is a signed value wide enough that no overflow can occur.
- R5: out_row and out_col give the selected point in the next stage's grid, as 2*row+1 and 2*col+1. Both are therefore always odd.
- R6: Equal scores are resolved toward the lower row, then the lower column.
- R7: Candidate points whose row or column falls outside 0..EDGE-1 take no part in the selection.
- R8: While out_valid is 1 and out_ready is 0, out_valid, out_row, out_col, out_metric and out_energy hold their values. out_energy equals the energies that were accepted with the event.
- R9: On an edge where out_valid and out_ready are both 1, the event leaves. On the next cycle out_valid is 0 and in_ready is 1.
- R10: A table write goes to the location at address (row*EDGE + col)*NS + sensor. The written coefficients take part in every later score.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Input event offered |
| in_ready | output | 1 | Stage is idle and accepts an event |
| in_energy | input | NS*EW | Sensor energies; sensor s occupies bits s*EW +: EW |
| in_row | input | CRW | Centre row in local grid |
| in_col | input | CRW | Centre column in local grid |
| out_valid | output | 1 | Result event offered |
| out_ready | input | 1 | Next stage accepts the result |
| out_energy | output | NS*EW | Energies of the event, forwarded |
| out_row | output | CRW+1 | Refined centre row for the next stage |
| out_col | output | CRW+1 | Refined centre column for the next stage |
| out_metric | output | MW | Winning score, signed |
| tbl_we | input | 1 | Coefficient write strobe |
| tbl_addr | input | AW | Coefficient address (row*EDGE+col)*NS+sensor |
| tbl_a | input | CW | Coefficient A, unsigned |
| tbl_b | input | CW | Coefficient B, unsigned |
| tbl_c | input | CW | Coefficient C, signed |

## Verification
All results become valid at one fixed edge: the 192nd rising edge after the accepting edge. The bench counts falling edges from the accept, so the count must be exactly 192 when out_valid is first seen high. The score, the refined centre and the forwarded energies are checked on that same falling edge. The handshake results follow one edge later. in_ready must already be low on the falling edge after the accept. in_ready must be back high on the falling edge after the edge where out_ready was taken. A checker counts cycles from each accept, so that the 192-cycle window does not need a long delay operator.

// File: rtl/pos_search_stage.sv
module pos_search_stage #(
  parameter int EW   = 12,
  parameter int CW   = 16,
  parameter int NS   = 64,
  parameter int EDGE = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [NS*EW-1:0]            in_energy,
  input  logic [$clog2(EDGE)-1:0]     in_row,
  input  logic [$clog2(EDGE)-1:0]     in_col,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [NS*EW-1:0]            out_energy,
  output logic [$clog2(EDGE):0]       out_row,
  output logic [$clog2(EDGE):0]       out_col,
  output logic signed [3*CW+$clog2(NS):0] out_metric,
  input  logic                        tbl_we,
  input  logic [$clog2(EDGE*EDGE*NS)-1:0] tbl_addr,
  input  logic [CW-1:0]               tbl_a,
  input  logic [CW-1:0]               tbl_b,
  input  logic [CW-1:0]               tbl_c
);
  localparam int CRW   = $clog2(EDGE);
  localparam int SW    = $clog2(NS);
  localparam int DEPTH = EDGE * EDGE * NS;
  localparam int AW    = $clog2(DEPTH);
  localparam int TW    = 3 * CW + 1;
  localparam int MW    = TW + SW;
  localparam int LAT   = 3 * NS;
  localparam int CNTW  = $clog2(LAT);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} state_t;
  state_t state;

  logic [CW-1:0] mem_a [DEPTH];
  logic [CW-1:0] mem_b [DEPTH];
  logic [CW-1:0] mem_c [DEPTH];

  always_ff @(posedge clk)
    if (tbl_we && int'(tbl_addr) < DEPTH) begin
      mem_a[tbl_addr] <= tbl_a;
      mem_b[tbl_addr] <= tbl_b;
      mem_c[tbl_addr] <= tbl_c;
    end

  logic [NS*EW-1:0]       energy_q;
  logic [CRW-1:0]         ctr_row, ctr_col;
  logic [CNTW-1:0]        cnt;
  logic                   found_q;
  logic signed [MW-1:0]   best_q;
  logic [CRW-1:0]         best_row, best_col;

  wire [SW-1:0] sens = SW'(cnt);
  wire [1:0]    pass = 2'(cnt >> SW);
  wire          last_sens = (sens == SW'(NS - 1));
  wire [EW-1:0] e_cur = energy_q[sens*EW +: EW];

  int  r_i;
  logic r_ok;
  always_comb begin
    r_i  = int'(ctr_row) + int'(pass) - 1;
    r_ok = (r_i >= 0) && (r_i < EDGE);
  end

  logic                 lane_ok  [3];
  logic [CRW-1:0]       lane_col [3];
  logic signed [MW-1:0] lane_sum [3];

  for (genvar l = 0; l < 3; l++) begin : g_lane
    int                   c_i;
    logic                 ok;
    logic [AW-1:0]        ad;
    logic [CW-1:0]        ext_e, a, b, absd;
    logic signed [CW-1:0] cs;
    logic [2*CW-1:0]      sq;
    logic [3*CW-1:0]      prod;
    logic signed [TW-1:0] term;
    logic signed [MW-1:0] acc;

    always_comb begin
      c_i  = int'(ctr_col) + l - 1;
      ok   = r_ok && (c_i >= 0) && (c_i < EDGE);
      ad   = ok ? AW'((r_i * EDGE + c_i) * NS + int'(sens)) : '0;
      a    = mem_a[ad];
      b    = mem_b[ad];
      cs   = $signed(mem_c[ad]);
      ext_e = CW'(e_cur);
      absd = (ext_e > a) ? ext_e - a : a - ext_e;
      sq   = (2*CW)'(absd) * (2*CW)'(absd);
      prod = (3*CW)'(sq) * (3*CW)'(b);
      term = $signed({1'b0, prod}) + TW'(cs);
    end

    assign lane_ok[l]  = ok;
    assign lane_col[l] = CRW'(c_i);
    assign lane_sum[l] = ((sens == '0) ? MW'(0) : acc) + MW'(term);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)             acc <= '0;
      else if (state == S_RUN) acc <= lane_sum[l];
  end

  logic                 nb_found;
  logic signed [MW-1:0] nb_metric;
  logic [CRW-1:0]       nb_row, nb_col;

  always_comb begin
    nb_found  = found_q;
    nb_metric = best_q;
    nb_row    = best_row;
    nb_col    = best_col;
    for (int l = 0; l < 3; l++)
      if (lane_ok[l] && (!nb_found || lane_sum[l] < nb_metric)) begin
        nb_found  = 1'b1;
        nb_metric = lane_sum[l];
        nb_row    = CRW'(r_i);
        nb_col    = lane_col[l];
      end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state    <= S_IDLE;
      energy_q <= '0;
      ctr_row  <= '0;
      ctr_col  <= '0;
      cnt      <= '0;
      found_q  <= 1'b0;
      best_q   <= '0;
      best_row <= '0;
      best_col <= '0;
    end else begin
      case (state)
        S_IDLE: if (in_valid) begin
          energy_q <= in_energy;
          ctr_row  <= in_row;
          ctr_col  <= in_col;
          cnt      <= '0;
          found_q  <= 1'b0;
          best_row <= in_row;
          best_col <= in_col;
          state    <= S_RUN;
        end
        S_RUN: begin
          cnt <= cnt + 1'b1;
          if (last_sens) begin
            found_q  <= nb_found;
            best_q   <= nb_metric;
            best_row <= nb_row;
            best_col <= nb_col;
          end
          if (cnt == CNTW'(LAT - 1)) state <= S_DONE;
        end
        S_DONE: if (out_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end

  assign in_ready   = (state == S_IDLE);
  assign out_valid  = (state == S_DONE);
  assign out_energy = energy_q;
  assign out_row    = {best_row, 1'b1};
  assign out_col    = {best_col, 1'b1};
  assign out_metric = best_q;
endmodule

// File: rtl/pos_search_stage_chk.sv
module pos_search_stage_chk #(
  parameter int LAT = 192,
  parameter int OCW = 3,
  parameter int MW  = 55,
  parameter int DW  = 768
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic           out_valid,
  input logic           out_ready,
  input logic [OCW-1:0] out_row,
  input logic [OCW-1:0] out_col,
  input logic [MW-1:0]  out_metric,
  input logic [DW-1:0]  out_energy
);
  logic [15:0] wait_cnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                     wait_cnt <= '0;
    else if (in_valid && in_ready)  wait_cnt <= '0;
    else if (wait_cnt != 16'hffff)  wait_cnt <= wait_cnt + 1'b1;

  p_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready && !out_valid);
  p_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
  p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> wait_cnt == 16'(LAT));
  p_odd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_row[0] && out_col[0]);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_row) && $stable(out_col)
      && $stable(out_metric) && $stable(out_energy));
  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> in_ready && !out_valid);
endmodule

bind pos_search_stage pos_search_stage_chk #(
  .LAT(3 * NS), .OCW($clog2(EDGE) + 1), .MW(3 * CW + 1 + $clog2(NS)), .DW(NS * EW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_row(out_row),
  .out_col(out_col), .out_metric(out_metric), .out_energy(out_energy)
);

// File: tb/sim_pos_search_stage.sv
module sim_pos_search_stage;
  localparam int EW = 12, CW = 16, NS = 64, EDGE = 3;
  localparam int DEPTH = EDGE * EDGE * NS;
  localparam int AW = $clog2(DEPTH);
  localparam int MW = 3 * CW + 1 + $clog2(NS);

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 0, tbl_we = 0;
  logic in_ready, out_valid;
  logic [NS*EW-1:0] in_energy = '0, out_energy;
  logic [1:0] in_row = '0, in_col = '0;
  logic [2:0] out_row, out_col;
  logic signed [MW-1:0] out_metric;
  logic [AW-1:0] tbl_addr = '0;
  logic [CW-1:0] tbl_a = '0, tbl_b = '0, tbl_c = '0;

  int errors = 0, checks = 0;
  int ta [DEPTH];
  int tb [DEPTH];
  int tc [DEPTH];
  int en [NS];

  always #5 clk = ~clk;

  pos_search_stage #(.EW(EW), .CW(CW), .NS(NS), .EDGE(EDGE)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_energy(in_energy), .in_row(in_row), .in_col(in_col),
    .out_valid(out_valid), .out_ready(out_ready), .out_energy(out_energy),
    .out_row(out_row), .out_col(out_col), .out_metric(out_metric),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_a(tbl_a), .tbl_b(tbl_b), .tbl_c(tbl_c));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int a, input int b, input int c);
    @(negedge clk);
    tbl_we = 1; tbl_addr = AW'(addr);
    tbl_a = CW'(a); tbl_b = CW'(b); tbl_c = CW'(c);
    ta[addr] = a; tb[addr] = b; tc[addr] = c;
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic load_table(input int seed, input bit flat);
    for (int i = 0; i < DEPTH; i++) begin
      int k = flat ? (i % NS) : i;
      int h = (k * 2654435 + seed * 40503 + 17) & 32'h7fffffff;
      wr(i, (h >> 3) % 4096, 1 + (h >> 13) % 15, ((h >> 7) % 2001) - 1000);
    end
  endtask

  function automatic longint score(input int r, input int c);
    longint s = 0;
    for (int k = 0; k < NS; k++) begin
      int ad = (r * EDGE + c) * NS + k;
      longint d = longint'(en[k]) - longint'(ta[ad]);
      s += d * d * longint'(tb[ad]) + longint'(tc[ad]);
    end
    return s;
  endfunction

  task automatic run_event(input int cr, input int cc, input int eseed, input int hold,
                           input string req);
    logic [NS*EW-1:0] packed_e;
    longint best = 0;
    int br = -1, bc = -1, n = 0;
    for (int k = 0; k < NS; k++) begin
      en[k] = (eseed * 37 + k * 101 + (k * k) % 53) % 4096;
      packed_e[k*EW +: EW] = EW'(en[k]);
    end
    for (int r = cr - 1; r <= cr + 1; r++)
      for (int c = cc - 1; c <= cc + 1; c++)
        if (r >= 0 && r < EDGE && c >= 0 && c < EDGE) begin
          longint s = score(r, c);
          if (br < 0 || s < best) begin best = s; br = r; bc = c; end
        end
    @(negedge clk);
    chk(in_ready == 1'b1, "R9 idle before event", longint'(in_ready), 1);
    in_valid = 1; in_energy = packed_e; in_row = 2'(cr); in_col = 2'(cc);
    @(negedge clk);
    in_energy = ~packed_e; in_row = 2'(2 - cr); in_col = 2'(2 - cc);
    chk(in_ready == 1'b0, "R2 busy after accept", longint'(in_ready), 0);
    while (!out_valid && n < 1000) begin @(negedge clk); n++; end
    in_valid = 0;
    chk(n == 3 * NS, {req, " R3 latency"}, n, 3 * NS);
    chk(longint'(out_metric) == best, {req, " R4 metric"}, longint'(out_metric), best);
    chk(out_row == 3'(2 * br + 1), {req, " R5 row"}, longint'(out_row), 2 * br + 1);
    chk(out_col == 3'(2 * bc + 1), {req, " R5 col"}, longint'(out_col), 2 * bc + 1);
    chk(out_energy == packed_e, {req, " R2 energies kept"}, 0, 0);
    repeat (hold) @(negedge clk);
    if (hold > 0) begin
      chk(out_valid && out_row == 3'(2 * br + 1) && out_col == 3'(2 * bc + 1)
          && longint'(out_metric) == best, "R8 hold", longint'(out_valid), 1);
      chk(out_energy == packed_e, "R8 energies held", 0, 0);
    end
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
    chk(in_ready && !out_valid, "R9 release", longint'(in_ready), 1);
  endtask

  task automatic t_reset;
    chk(in_ready == 1'b1, "R1 in_ready", longint'(in_ready), 1);
    chk(out_valid == 1'b0, "R1 out_valid", longint'(out_valid), 0);
  endtask

  task automatic t_tie;
    load_table(5, 1'b1);
    run_event(1, 1, 3, 0, "R6 tie centre");
    run_event(2, 2, 4, 0, "R6 R7 tie corner");
  endtask

  task automatic t_random;
    load_table(11, 1'b0);
    run_event(1, 1, 7, 0, "R4 centre");
    run_event(1, 1, 19, 4, "R4 R8 hold");
    run_event(0, 0, 23, 0, "R7 corner low");
    run_event(0, 2, 29, 0, "R7 edge");
  endtask

  task automatic t_write;
    for (int k = 0; k < NS; k++)
      wr((2 * EDGE + 0) * NS + k, (k * 7) % 4096, 0, -32768);
    run_event(1, 1, 0, 0, "R10 write");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_tie;
    t_random;
    t_write;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule